// File: doc/BRIEF.md
# Iterative SHA-256 Compression Core with Retimed Round and Circulating Digest

This block runs the SHA-256 compression function on one 512-bit message block at a time, one round per clock. The caller supplies the expanded schedule word and the round constant for the index the core asks for on `sched_idx`. Message padding and schedule expansion are done elsewhere. Only the two working variables that need arithmetic (the first and the fifth) are computed each round. The other five registers shift, and the eighth variable is never stored. The sum of that eighth variable, the constant and the schedule word is formed one cycle early, in a pipeline register. This removes three operands from the round's addition tree.

The eight-word chaining value lives in a circular buffer of 32-bit words that also serves as the block's narrow I/O. Each write pushes one word of a custom initial value into the tail of the buffer. Each read strobe rotates the buffer by one word, so the word at position 0 appears on `dig_word`. At the end of a block, the buffer is updated by two adders in place: one takes the history of the first variable and one takes the history of the fifth. Words 0 and 4 of the chaining value go straight into the final round's sums. A new `start` hashes the next block on top of the current buffer contents, so multi-block messages chain without any software help.

Top module: `sha_rr_core`

## Requirements
- R1: After reset the buffer holds the standard SHA-256 initial hash words (6a09e667 at position 0, 5be0cd19 at position 7), `dig_ptr` is 0 and `done` is 0.
- R2: A `start` accepted in the idle state begins one load cycle followed by 64 round cycles. `sched_idx` is 0 in the load cycle and r+1 during round r. `done` rises on the 65th rising edge after the edge that accepted `start`.
- R3: For the single padded block of the three-byte message "abc" starting from the standard initial value, the buffer afterwards holds ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad (position 0 first).
- R4: Each block compresses onto the buffer contents left by the previous block, so consecutive blocks give the standard chained SHA-256 result.
- R5: Eight idle-state writes with `iv_wr` place the written words at positions 0 to 7 in write order. A block then compresses from that custom initial value.
- R6: `dig_word` always shows buffer position 0. Each accepted `rd_next` rotates the buffer by one word toward position 0, and eight reads restore it. `dig_ptr` advances by 1, modulo 8, on every accepted `iv_wr` or `rd_next`.
- R7: While a block is in progress, `start`, `iv_wr` and `rd_next` have no effect: `dig_ptr` does not move and the digest is unchanged by them. The buffer is not modified before round 61.
- R8: In the idle state `start` takes priority over `iv_wr`, and `iv_wr` over `rd_next`. A write asserted together with a read pushes the written word rather than rotating.
- R9: `start` accepted clears `done` on the next edge. Otherwise `done` stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin compressing one block (idle only) |
| iv_wr | input | 1 | Push `iv_word` into the buffer tail (idle only) |
| iv_word | input | 32 | Initial-value word to push |
| rd_next | input | 1 | Rotate the buffer by one word (idle only) |
| w_in | input | 32 | Schedule word for index `sched_idx` |
| k_in | input | 32 | Round constant for index `sched_idx` |
| sched_idx | output | 6 | Round index whose word and constant are wanted this cycle |
| dig_word | output | 32 | Buffer word at position 0 |
| dig_ptr | output | 3 | Count of buffer shifts, modulo 8 |
| done | output | 1 | A block has completed since the last start |

## Verification
The assertions assume that `w_in` and `k_in` are valid in the same cycle as the index on `sched_idx`. They also assume that nothing about the result depends on control strobes sent while the core is busy. The bench therefore drives the schedule word and the constant combinationally from its own tables, indexed by `sched_idx`. It deliberately holds `start`, `iv_wr` and `rd_next` high through most of a block, so that the assertions that the buffer and pointer stay quiet are exercised against real activity on those inputs. Digest contents are compared against a separate reference model of the compression function in the bench. They are also compared against the published "abc" vector.

// File: rtl/sha_rr_pkg.sv
package sha_rr_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_ROUNDS = 64;
    localparam int NUM_WORDS  = 8;
    localparam int HALF       = NUM_WORDS / 2;
    localparam int RND_W      = $clog2(NUM_ROUNDS);
    localparam int PTR_W      = $clog2(NUM_WORDS);
    localparam int ROT_FIRST  = NUM_ROUNDS - 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_ROUND
    } phase_t;

    // working variables that are kept in registers; the eighth is folded
    // into the precomputed sum and never stored
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
    } wvars_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_s0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic word_t init_word(input int idx);
        case (idx)
            0:       return 32'h6a09e667;
            1:       return 32'hbb67ae85;
            2:       return 32'h3c6ef372;
            3:       return 32'ha54ff53a;
            4:       return 32'h510e527f;
            5:       return 32'h9b05688c;
            6:       return 32'h1f83d9ab;
            default: return 32'h5be0cd19;
        endcase
    endfunction

endpackage

// File: rtl/sha_rr_ctrl.sv
module sha_rr_ctrl
    import sha_rr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             iv_wr,
    input  logic             rd_next,
    output phase_t           phase,
    output logic [RND_W-1:0] rnd,
    output logic             done,
    output logic [PTR_W-1:0] ptr,
    output logic             shift_en,
    output logic             take_iv,
    output logic             rot_step,
    output logic             fin_step,
    output logic [RND_W-1:0] sched_idx
);

    localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS - 1);
    localparam logic [RND_W-1:0] ROT0 = RND_W'(ROT_FIRST);

    logic idle;
    assign idle = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rnd   <= '0;
            done  <= 1'b0;
            ptr   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        done  <= 1'b0;
                    end else if (iv_wr || rd_next) begin
                        ptr <= ptr + 1'b1;
                    end
                end
                PH_LOAD: begin
                    phase <= PH_ROUND;
                    rnd   <= '0;
                end
                PH_ROUND: begin
                    if (rnd == LAST) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        rnd <= rnd + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        shift_en  = idle && !start && (iv_wr || rd_next);
        take_iv   = iv_wr;
        rot_step  = (phase == PH_ROUND) && (rnd >= ROT0) && (rnd != LAST);
        fin_step  = (phase == PH_ROUND) && (rnd == LAST);
        sched_idx = (phase == PH_LOAD) ? '0 : rnd + 1'b1;
    end

endmodule

// File: rtl/sha_rr_pre.sv
module sha_rr_pre
    import sha_rr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t h_seed,
    input  word_t g_cur,
    input  word_t k_in,
    input  word_t w_in,
    output word_t p_q
);

    word_t h_src;
    assign h_src = load ? h_seed : g_cur;

    // first pipeline stage: next round's h + K + W
    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= h_src + k_in + w_in;
    end

endmodule

// File: rtl/sha_rr_round.sv
module sha_rr_round
    import sha_rr_pkg::*;
(
    input  wvars_t vars,
    input  word_t  p_sum,
    input  logic   zero_ops,
    input  word_t  inj_a,
    input  word_t  inj_e,
    output word_t  a_new,
    output word_t  e_new
);

    wvars_t v;
    word_t  p;
    word_t  t1;

    always_comb begin
        v     = zero_ops ? '0 : vars;
        p     = zero_ops ? '0 : p_sum;
        t1    = p + big_s1(v.e) + choose(v.e, v.f, v.g);
        a_new = t1 + big_s0(v.a) + majority(v.a, v.b, v.c) + inj_a;
        e_new = t1 + v.d + inj_e;
    end

endmodule

// File: rtl/sha_rr_digest.sv
module sha_rr_digest
    import sha_rr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  take_iv,
    input  word_t iv_word,
    input  logic  rot_step,
    input  logic  fin_step,
    input  word_t tail_a,
    input  word_t tail_e,
    input  word_t new_a,
    input  word_t new_e,
    output word_t dw_o [NUM_WORDS]
);

    word_t dw     [NUM_WORDS];
    word_t tail_v [2];
    word_t new_v  [2];
    word_t sum_v  [2];

    assign tail_v[0] = tail_a;
    assign tail_v[1] = tail_e;
    assign new_v[0]  = new_a;
    assign new_v[1]  = new_e;

    // one adder per half, always reading the last word of that half
    for (genvar h = 0; h < 2; h++) begin : g_add
        assign sum_v[h] = tail_v[h] + dw[h*HALF + HALF - 1];
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam int  H       = i / HALF;
        localparam int  J       = i % HALF;
        localparam int  BASE    = H * HALF;
        localparam int  NXT     = (i + 1) % NUM_WORDS;
        localparam int  PRV     = BASE + ((J + HALF - 1) % HALF);
        localparam int  FSRC    = BASE + ((J + HALF - 2) % HALF);
        localparam bit  IS_TAIL = (i == NUM_WORDS - 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                dw[i] <= init_word(i);
            end else if (shift_en) begin
                dw[i] <= (IS_TAIL && take_iv) ? iv_word : dw[NXT];
            end else if (rot_step) begin
                dw[i] <= (J == 0) ? sum_v[H] : dw[PRV];
            end else if (fin_step) begin
                dw[i] <= (J == 0) ? new_v[H] : ((J == 1) ? sum_v[H] : dw[FSRC]);
            end
        end
    end

    assign dw_o = dw;

endmodule

// File: rtl/sha_rr_core.sv
module sha_rr_core
    import sha_rr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        iv_wr,
    input  logic [31:0] iv_word,
    input  logic        rd_next,
    input  logic [31:0] w_in,
    input  logic [31:0] k_in,
    output logic [5:0]  sched_idx,
    output logic [31:0] dig_word,
    output logic [2:0]  dig_ptr,
    output logic        done
);

    phase_t           phase;
    logic [RND_W-1:0] rnd;
    logic             shift_en;
    logic             take_iv;
    logic             rot_step;
    logic             fin_step;
    logic             in_load;
    logic             in_round;
    wvars_t           vars;
    word_t            p_q;
    word_t            a_new;
    word_t            e_new;
    word_t            inj_a;
    word_t            inj_e;
    word_t            dw [NUM_WORDS];

    sha_rr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .iv_wr     (iv_wr),
        .rd_next   (rd_next),
        .phase     (phase),
        .rnd       (rnd),
        .done      (done),
        .ptr       (dig_ptr),
        .shift_en  (shift_en),
        .take_iv   (take_iv),
        .rot_step  (rot_step),
        .fin_step  (fin_step),
        .sched_idx (sched_idx)
    );

    assign in_load  = (phase == PH_LOAD);
    assign in_round = (phase == PH_ROUND);

    sha_rr_pre u_pre (
        .clk    (clk),
        .rst    (rst),
        .load   (in_load),
        .h_seed (dw[NUM_WORDS-1]),
        .g_cur  (vars.g),
        .k_in   (k_in),
        .w_in   (w_in),
        .p_q    (p_q)
    );

    // chaining words enter the first and fifth sums: at load they seed the
    // variables, in the last round they are the digest addition
    always_comb begin
        if (in_load) begin
            inj_a = dw[0];
            inj_e = dw[HALF];
        end else if (fin_step) begin
            inj_a = dw[HALF-2];
            inj_e = dw[NUM_WORDS-2];
        end else begin
            inj_a = '0;
            inj_e = '0;
        end
    end

    sha_rr_round u_round (
        .vars     (vars),
        .p_sum    (p_q),
        .zero_ops (in_load),
        .inj_a    (inj_a),
        .inj_e    (inj_e),
        .a_new    (a_new),
        .e_new    (e_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vars <= '0;
        end else if (in_load) begin
            vars <= '{a: a_new, b: dw[1], c: dw[2], d: dw[3],
                      e: e_new, f: dw[5], g: dw[6]};
        end else if (in_round) begin
            vars <= '{a: a_new, b: vars.a, c: vars.b, d: vars.c,
                      e: e_new, f: vars.e, g: vars.f};
        end
    end

    sha_rr_digest u_digest (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .take_iv  (take_iv),
        .iv_word  (iv_word),
        .rot_step (rot_step),
        .fin_step (fin_step),
        .tail_a   (vars.a),
        .tail_e   (vars.e),
        .new_a    (a_new),
        .new_e    (e_new),
        .dw_o     (dw)
    );

    assign dig_word = dw[0];

endmodule

// File: rtl/sha_rr_chk.sv
module sha_rr_chk
    import sha_rr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input phase_t           phase,
    input logic [RND_W-1:0] rnd,
    input logic             start,
    input logic             iv_wr,
    input logic             rd_next,
    input logic [5:0]       sched_idx,
    input logic [31:0]      dig_word,
    input logic [2:0]       dig_ptr,
    input logic             done
);

    logic [7:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst || phase == PH_IDLE) lat_cnt <= '0;
        else                         lat_cnt <= lat_cnt + 1'b1;
    end

    AST_LOAD_IDX: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD) |-> (sched_idx == 6'd0)); // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ROUND && $past(phase) == PH_ROUND) |-> (sched_idx == 6'($past(sched_idx) + 1))); // R2

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (lat_cnt == 8'(NUM_ROUNDS + 1))); // R2

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> !done); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !(phase == PH_IDLE && start)) |=> done); // R9

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start && (iv_wr || rd_next)) |=> (dig_ptr == 3'($past(dig_ptr) + 1))); // R6

    AST_BUSY_PTR: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(dig_ptr)); // R7

    AST_RING_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD || (phase == PH_ROUND && rnd < RND_W'(ROT_FIRST))) |=> $stable(dig_word)); // R7

    AST_START_FIRST: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> $stable(dig_ptr)); // R8

endmodule

bind sha_rr_core sha_rr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .rnd       (rnd),
    .start     (start),
    .iv_wr     (iv_wr),
    .rd_next   (rd_next),
    .sched_idx (sched_idx),
    .dig_word  (dig_word),
    .dig_ptr   (dig_ptr),
    .done      (done)
);

// File: tb/sha_rr_core_tb.sv
module sha_rr_core_tb;

    localparam logic [31:0] KT [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    localparam logic [31:0] ABC_DIG [8] = '{
        32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
        32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        iv_wr = 1'b0;
    logic [31:0] iv_word = '0;
    logic        rd_next = 1'b0;
    logic [31:0] w_in;
    logic [31:0] k_in;
    logic [5:0]  sched_idx;
    logic [31:0] dig_word;
    logic [2:0]  dig_ptr;
    logic        done;

    logic [31:0] wsch [64];
    logic [31:0] blk  [16];
    logic [31:0] mdl  [8];
    int          nchk = 0;
    int          nerr = 0;
    int          eptr = 0;

    always #4 clk = ~clk;

    assign w_in = wsch[sched_idx];
    assign k_in = KT[sched_idx];

    sha_rr_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .iv_wr     (iv_wr),
        .iv_word   (iv_word),
        .rd_next   (rd_next),
        .w_in      (w_in),
        .k_in      (k_in),
        .sched_idx (sched_idx),
        .dig_word  (dig_word),
        .dig_ptr   (dig_ptr),
        .done      (done)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expand blk into wsch and advance the reference chaining value mdl
    task automatic model_block();
        logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
        for (int t = 0; t < 16; t++) wsch[t] = blk[t];
        for (int t = 16; t < 64; t++)
            wsch[t] = (rr(wsch[t-2], 17) ^ rr(wsch[t-2], 19) ^ (wsch[t-2] >> 10)) + wsch[t-7]
                    + (rr(wsch[t-15], 7) ^ rr(wsch[t-15], 18) ^ (wsch[t-15] >> 3)) + wsch[t-16];
        a = mdl[0]; b = mdl[1]; c = mdl[2]; d = mdl[3];
        e = mdl[4]; f = mdl[5]; g = mdl[6]; h = mdl[7];
        for (int t = 0; t < 64; t++) begin
            t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KT[t] + wsch[t];
            t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
            h = g; g = f; f = e; e = d + t1;
            d = c; c = b; b = a; a = t1 + t2;
        end
        mdl[0] += a; mdl[1] += b; mdl[2] += c; mdl[3] += d;
        mdl[4] += e; mdl[5] += f; mdl[6] += g; mdl[7] += h;
    endtask

    // start is driven before edge E0; done set at E65 is seen at the 66th negedge
    task automatic run_block(input string req, input bit disturb, input bit with_iv);
        int n = 0;
        start = 1'b1;
        iv_wr = with_iv;
        iv_word = 32'hfeedf00d;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                iv_wr = 1'b0;
                chk({req, " R9 done cleared"}, {31'd0, done}, 32'd0);
                chk({req, " R2 load index"}, {26'd0, sched_idx}, 32'd0);
            end
            if (n == 2) chk({req, " R2 round0 index"}, {26'd0, sched_idx}, 32'd1);
            if (disturb) begin
                if (n >= 5 && n <= 60) begin
                    start = 1'b1; iv_wr = 1'b1; rd_next = 1'b1; iv_word = 32'hdeadbeef;
                end else begin
                    start = 1'b0; iv_wr = 1'b0; rd_next = 1'b0;
                end
            end
        end while (!done && n < 300);
        chk({req, " R2 latency"}, 32'(n), 32'd66);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 8; i++) begin
            chk(req, dig_word, mdl[i]);
            rd_next = 1'b1;
            @(negedge clk);
            rd_next = 1'b0;
        end
        chk({req, " R6 ptr wraps"}, {29'd0, dig_ptr}, 32'(eptr));
    endtask

    task automatic test_reset();
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        mdl[0] = 32'h6a09e667; mdl[1] = 32'hbb67ae85; mdl[2] = 32'h3c6ef372; mdl[3] = 32'ha54ff53a;
        mdl[4] = 32'h510e527f; mdl[5] = 32'h9b05688c; mdl[6] = 32'h1f83d9ab; mdl[7] = 32'h5be0cd19;
        chk("R1 word0", dig_word, 32'h6a09e667);
        chk("R1 ptr", {29'd0, dig_ptr}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        read_all("R6 reset readout");
    endtask

    task automatic test_abc();
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0] = 32'h61626380;
        blk[15] = 32'h00000018;
        model_block();
        run_block("abc", 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            chk("R3 abc digest", dig_word, ABC_DIG[i]);
            rd_next = 1'b1;
            @(negedge clk);
            rd_next = 1'b0;
        end
        repeat (5) @(negedge clk);
        chk("R9 done held", {31'd0, done}, 32'd1);
    endtask

    task automatic test_chain();
        for (int i = 0; i < 16; i++) blk[i] = 32'(i) * 32'h9e3779b9 ^ 32'h0badc0de;
        model_block();
        run_block("chain", 1'b0, 1'b0);
        read_all("R4 chained digest");
    endtask

    task automatic test_custom_iv();
        for (int i = 0; i < 8; i++) begin
            iv_word = 32'h11111111 * 32'(i + 1) ^ 32'ha5a50000;
            mdl[i] = iv_word;
            iv_wr = 1'b1;
            @(negedge clk);
            iv_wr = 1'b0;
        end
        chk("R6 ptr after 8 writes", {29'd0, dig_ptr}, 32'(eptr));
        read_all("R5 custom iv readback");
        for (int i = 0; i < 16; i++) blk[i] = 32'h01010101 << (i % 8) ^ 32'(i);
        model_block();
        run_block("custom", 1'b0, 1'b0);
        read_all("R5 digest from custom iv");
    endtask

    task automatic test_busy();
        for (int i = 0; i < 16; i++) blk[i] = ~(32'(i) * 32'h01000193);
        model_block();
        run_block("busy", 1'b1, 1'b0);
        chk("R7 ptr unmoved", {29'd0, dig_ptr}, 32'(eptr));
        read_all("R7 digest undisturbed");
    endtask

    task automatic test_priority();
        logic [31:0] old1;
        for (int i = 0; i < 16; i++) blk[i] = 32'h5a5a5a5a + 32'(i);
        model_block();
        run_block("prio", 1'b0, 1'b1);
        chk("R8 start over write ptr", {29'd0, dig_ptr}, 32'(eptr));
        read_all("R8 start over write digest");
        old1 = mdl[1];
        iv_word = 32'hc001d00d;
        iv_wr = 1'b1;
        rd_next = 1'b1;
        @(negedge clk);
        iv_wr = 1'b0;
        rd_next = 1'b0;
        eptr = (eptr + 1) % 8;
        chk("R8 write over read ptr", {29'd0, dig_ptr}, 32'(eptr));
        chk("R8 write over read head", dig_word, old1);
        for (int i = 0; i < 7; i++) mdl[i] = mdl[i+1];
        mdl[7] = 32'hc001d00d;
        read_all("R8 write over read ring");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_abc();
        test_chain();
        test_custom_iv();
        test_busy();
        test_priority();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule